// File: doc/BRIEF.md
# Exclusive Access Reservation Unit

This unit sits next to the load/store stage of a 32-bit processor and turns a pair of instructions into a simple atomic read-modify-write. The first instruction is a load flagged as exclusive. The second is a store flagged as exclusive, and it succeeds only if nothing has broken the reservation since that load. The unit decodes the qualifier bits of register-form memory instructions. It masks exclusive addresses down to a word boundary and keeps a single reservation bit. It also decides whether a conditional store reaches the memory port.

Success or failure is reported through a one-cycle write to the processor's carry flag, with 0 meaning success and 1 meaning failure. No general register is written for this. Entering an interrupt or exception handler drops the reservation. There is no address tag: the bit alone decides. Outputs are registered and appear one cycle after the instruction is issued.

Top module: `excl_resv_unit`

## Requirements
- R1: `mem_size` carries the two lowest instruction bits (0, 1 and 2 mean 1, 2 and 4 bytes); the access width in bytes is 1 shifted left by that code.
- R2: Qualifiers are decoded only when `reg_form` is 1: instruction bit 9 sets `mem_rev` (byte-reversed) and bit 10 marks the access exclusive; with `reg_form` 0 both are taken as 0.
- R3: An exclusive access drives `mem_addr` with its two lowest bits zero and never raises `align_fault`; an ordinary access whose address is not a multiple of its size raises `align_fault` for one cycle and issues no memory request.
- R4: An exclusive load issues a read request (`mem_we`=0), sets the reservation, and pulses `carry_we` with `carry_val`=0.
- R5: An exclusive store issued while the reservation is clear issues no memory request and pulses `carry_we` with `carry_val`=1.
- R6: An exclusive store issued while the reservation is set issues a write request with `mem_wdata` and pulses `carry_we` with `carry_val`=0.
- R7: A `trap_enter` pulse clears the reservation; an instruction issued in the same cycle as `trap_enter` is dropped (no request, no carry write, no fault).
- R8: The reservation persists across any number of ordinary loads and stores, which leave it unchanged.
- R9: Every exclusive store clears the reservation, whether it succeeds or fails, so a second exclusive store without a new exclusive load fails.
- R10: After reset all outputs are 0 and the reservation is clear.
- R11: Every output reflects the instruction issued at the previous clock edge; `carry_we` is high for exactly one cycle per exclusive access, in the same cycle as that access's memory request or its suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | A memory instruction executes this cycle |
| is_load | input | 1 | The issued instruction is a load |
| is_store | input | 1 | The issued instruction is a store |
| reg_form | input | 1 | Register-form encoding (qualifiers valid) |
| instr | input | 32 | Instruction word |
| addr | input | 32 | Effective address from the address stage |
| wdata | input | 32 | Store data |
| trap_enter | input | 1 | Interrupt or exception handler entry |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_size | output | 2 | Access size code |
| mem_rev | output | 1 | Byte-reversed access |
| mem_wdata | output | 32 | Request write data |
| carry_we | output | 1 | Carry flag write enable pulse |
| carry_val | output | 1 | Carry value: 0 success, 1 failure |
| align_fault | output | 1 | Unaligned ordinary access fault |

## Verification
The bench builds the unit with its defaults: 32-bit address and data, qualifier bits at positions 9 and 10, and two masked address bits. With these values, every exclusive address in the tests, such as one ending in 1, 2 or 3, has to reach memory on the word boundary below it. The faulting halfword and word cases become reachable in the same run. The directed sequences cover the pass and fail outcomes of the conditional store. They also cover a reservation broken by a trap, a trap that coincides with an issue, and a reservation held across ordinary traffic.

// File: rtl/excl_pkg.sv
// Shared types for the exclusive access reservation unit.
// Assumes a two-bit size code in the lowest instruction bits.
package excl_pkg;

    // Decoded qualifiers of one memory instruction
    typedef struct packed {
        logic       rev;
        logic       excl;
        logic [1:0] size;
    } qual_t;

endpackage

// File: rtl/excl_decode.sv
// Qualifier decode and address conditioning.
// Pulls the size, reverse and exclusive qualifiers out of the instruction word.
// Masks exclusive addresses to the word boundary and flags unaligned ordinary
// accesses. Purely combinational; assumes the address is already computed.
module excl_decode
    import excl_pkg::*;
#(
    parameter int AW       = 32,
    parameter int IW       = 32,
    parameter int REV_BIT  = 9,
    parameter int EXCL_BIT = 10,
    parameter int AB       = 2
) (
    input  logic [IW-1:0] instr,
    input  logic          reg_form,
    input  logic [AW-1:0] addr,
    output qual_t         q,
    output logic [AW-1:0] addr_eff,
    output logic          misalign
);
    logic [AB:0] low_mask;

    // Qualifier extraction: immediate forms carry no qualifiers
    always_comb begin
        q.size = instr[1:0];
        q.rev  = reg_form & instr[REV_BIT];
        q.excl = reg_form & instr[EXCL_BIT];
    end

    // Address masking for exclusive accesses and fault detection for others
    always_comb begin
        low_mask = (AB+1)'((1 << q.size) - 1);
        addr_eff = addr;
        misalign = 1'b0;
        if (q.excl) begin
            addr_eff[AB-1:0] = '0;
        end else begin
            misalign = |(addr[AB:0] & low_mask);
        end
    end
endmodule

// File: rtl/resv_flag.sv
// Single reservation bit.
// Set by an exclusive load, cleared by any exclusive store and by trap entry.
// Ordinary accesses leave it untouched. Assumes fire excludes trap cycles.
module resv_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic is_load,
    input  logic is_store,
    input  logic excl,
    input  logic trap_enter,
    output logic resv
);
    // Reservation state update at execution time
    always_ff @(posedge clk) begin
        if (!rst_n)                        resv <= 1'b0;
        else if (trap_enter)               resv <= 1'b0;
        else if (fire && excl && is_load)  resv <= 1'b1;
        else if (fire && excl && is_store) resv <= 1'b0;
    end

    // R7: a trap always leaves the reservation clear
    a_r7_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> !resv);
    // R4: an exclusive load leaves the reservation set
    a_r4_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && excl && is_load) |=> resv);
    // R9: an exclusive store leaves the reservation clear
    a_r9_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && excl && is_store) |=> !resv);
    // R8: ordinary accesses keep the reservation
    a_r8_ordinary_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !excl && !trap_enter) |=> $stable(resv));
endmodule

// File: rtl/excl_commit.sv
// Memory request and carry update stage.
// Registers the memory request, the carry write pulse and the alignment fault
// for the instruction that fires this cycle. A conditional store without a
// reservation is suppressed.
module excl_commit
    import excl_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int AB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          is_store,
    input  qual_t         q,
    input  logic [AW-1:0] addr_eff,
    input  logic          misalign,
    input  logic [DW-1:0] wdata,
    input  logic          resv,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic          mem_rev,
    output logic [DW-1:0] mem_wdata,
    output logic          carry_we,
    output logic          carry_val,
    output logic          align_fault
);
    logic blocked;

    // A conditional store is blocked when no reservation is held
    always_comb blocked = q.excl & is_store & ~resv;

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req     <= 1'b0;
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_size    <= '0;
            mem_rev     <= 1'b0;
            mem_wdata   <= '0;
            carry_we    <= 1'b0;
            carry_val   <= 1'b0;
            align_fault <= 1'b0;
        end else begin
            mem_req     <= fire & ~misalign & ~blocked;
            mem_we      <= fire & is_store;
            mem_addr    <= fire ? addr_eff : '0;
            mem_size    <= fire ? q.size : '0;
            mem_rev     <= fire & q.rev;
            mem_wdata   <= (fire & is_store) ? wdata : '0;
            carry_we    <= fire & q.excl;
            carry_val   <= fire & q.excl & blocked;
            align_fault <= fire & misalign;
        end
    end

    // R5: a failed conditional store never reaches memory
    a_r5_fail_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we && carry_val) |-> !mem_req);
    // R6: a successful exclusive access always carries a request
    a_r6_pass_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we && !carry_val) |-> mem_req);
    // R3: exclusive accesses are word aligned and never fault
    a_r3_excl_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |-> (mem_addr[AB-1:0] == '0 && !align_fault));
    // R3: a fault never comes with a request
    a_r3_fault_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> !mem_req);
    // R11: the carry write is a single-cycle pulse per exclusive access
    a_r11_carry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we && !fire) |=> !carry_we);
endmodule

// File: rtl/excl_resv_unit.sv
// Exclusive access reservation unit (top).
// Wires decode, reservation and commit stages. An instruction fires when issue
// is high with a load or store and no trap is entered in the same cycle.
module excl_resv_unit
    import excl_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int IW       = 32,
    parameter int REV_BIT  = 9,
    parameter int EXCL_BIT = 10,
    parameter int AB       = $clog2(DW / 8)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          is_load,
    input  logic          is_store,
    input  logic          reg_form,
    input  logic [IW-1:0] instr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          trap_enter,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic          mem_rev,
    output logic [DW-1:0] mem_wdata,
    output logic          carry_we,
    output logic          carry_val,
    output logic          align_fault
);
    qual_t         q;
    logic [AW-1:0] addr_eff;
    logic          misalign;
    logic          fire;
    logic          resv;

    // Instruction acceptance: a trap in the same cycle drops it
    always_comb fire = issue & (is_load | is_store) & ~trap_enter;

    excl_decode #(
        .AW(AW), .IW(IW), .REV_BIT(REV_BIT), .EXCL_BIT(EXCL_BIT), .AB(AB)
    ) u_decode (
        .instr(instr), .reg_form(reg_form), .addr(addr),
        .q(q), .addr_eff(addr_eff), .misalign(misalign)
    );

    resv_flag u_resv (
        .clk(clk), .rst_n(rst_n), .fire(fire), .is_load(is_load),
        .is_store(is_store), .excl(q.excl), .trap_enter(trap_enter),
        .resv(resv)
    );

    excl_commit #(.AW(AW), .DW(DW), .AB(AB)) u_commit (
        .clk(clk), .rst_n(rst_n), .fire(fire), .is_store(is_store), .q(q),
        .addr_eff(addr_eff), .misalign(misalign), .wdata(wdata), .resv(resv),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_rev(mem_rev), .mem_wdata(mem_wdata),
        .carry_we(carry_we), .carry_val(carry_val), .align_fault(align_fault)
    );

    // R7: a trap cycle produces no request and no carry write
    a_r7_trap_drops: assert property (@(posedge clk) disable iff (!rst_n)
        trap_enter |=> (!mem_req && !carry_we && !align_fault));
endmodule

// File: tb/excl_resv_unit_test.sv
// Directed bench for the exclusive access reservation unit.
module excl_resv_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0, is_load = 1'b0, is_store = 1'b0, reg_form = 1'b0;
    logic [31:0] instr = '0, addr = '0, wdata = '0;
    logic        trap_enter = 1'b0;
    logic        mem_req, mem_we, mem_rev, carry_we, carry_val, align_fault;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    excl_resv_unit uut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .is_load(is_load),
        .is_store(is_store), .reg_form(reg_form), .instr(instr), .addr(addr),
        .wdata(wdata), .trap_enter(trap_enter), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_rev(mem_rev), .mem_wdata(mem_wdata), .carry_we(carry_we),
        .carry_val(carry_val), .align_fault(align_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one instruction for one cycle; outputs are sampled after the edge
    task automatic op(input bit st, input bit rf, input bit ex, input bit rv,
                      input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] d, input bit trap);
        @(negedge clk);
        issue = 1'b1; is_load = !st; is_store = st; reg_form = rf;
        instr = {21'd0, ex, rv, 7'd0, sz}; addr = a; wdata = d; trap_enter = trap;
        @(posedge clk); #1;
        @(negedge clk);
        issue = 1'b0; is_load = 1'b0; is_store = 1'b0; trap_enter = 1'b0;
    endtask

    task automatic trap_pulse();
        @(negedge clk); trap_enter = 1'b1;
        @(negedge clk); trap_enter = 1'b0;
    endtask

    // Outputs are already registered when op returns (sampled before next edge)
    task automatic t_reset();
        chk("R10 mem_req", mem_req, 0);
        chk("R10 carry_we", carry_we, 0);
        chk("R10 align_fault", align_fault, 0);
        chk("R10 mem_addr", mem_addr, 0);
        // R10: a store-exclusive right after reset fails
        op(1, 1, 1, 0, 2, 32'h40, 32'h1, 0);
        chk("R10 no resv carry", carry_val, 1);
        chk("R10 no resv req", mem_req, 0);
    endtask

    task automatic t_pair_success();
        op(0, 1, 1, 0, 2, 32'h1003, 0, 0);
        chk("R4 req", mem_req, 1);
        chk("R4 read", mem_we, 0);
        chk("R3 masked", mem_addr, 32'h1000);
        chk("R3 no fault", align_fault, 0);
        chk("R4 carry_we", carry_we, 1);
        chk("R4 carry_val", carry_val, 0);
        @(posedge clk); #1;
        chk("R11 carry one cycle", carry_we, 0);
        op(1, 1, 1, 0, 2, 32'h1002, 32'hCAFE0001, 0);
        chk("R6 req", mem_req, 1);
        chk("R6 write", mem_we, 1);
        chk("R6 data", mem_wdata, 32'hCAFE0001);
        chk("R3 store masked", mem_addr, 32'h1000);
        chk("R6 carry", {carry_we, carry_val}, 2'b10);
    endtask

    task automatic t_second_store_fails();
        op(1, 1, 1, 0, 2, 32'h1000, 32'h2, 0);
        chk("R9 second fails carry", {carry_we, carry_val}, 2'b11);
        chk("R9 second no req", mem_req, 0);
    endtask

    task automatic t_trap_between();
        op(0, 1, 1, 0, 2, 32'h2001, 0, 0);
        trap_pulse();
        op(1, 1, 1, 0, 2, 32'h2001, 32'h3, 0);
        chk("R7 trap breaks resv", {mem_req, carry_val}, 2'b01);
        // trap coinciding with an issue drops the instruction
        op(0, 1, 1, 0, 2, 32'h2000, 0, 1);
        chk("R7 dropped req", mem_req, 0);
        chk("R7 dropped carry", carry_we, 0);
        op(1, 1, 1, 0, 2, 32'h2000, 32'h4, 0);
        chk("R7 dropped load no resv", carry_val, 1);
    endtask

    task automatic t_persist();
        op(0, 1, 1, 0, 2, 32'h3000, 0, 0);
        op(0, 1, 0, 0, 2, 32'h3004, 0, 0);
        chk("R8 ordinary load no carry", carry_we, 0);
        op(1, 0, 0, 0, 1, 32'h3006, 32'h5, 0);
        chk("R8 ordinary store req", mem_req, 1);
        op(1, 1, 1, 0, 2, 32'h3000, 32'h6, 0);
        chk("R8 resv kept", {mem_req, carry_val}, 2'b10);
    endtask

    task automatic t_qualifiers();
        // immediate form: bit 10 set but not exclusive, so unaligned word faults
        op(0, 0, 1, 1, 2, 32'h4001, 0, 0);
        chk("R2 imm no excl", carry_we, 0);
        chk("R2 imm no rev", mem_rev, 0);
        chk("R3 ord fault", {align_fault, mem_req}, 2'b10);
        op(0, 1, 0, 1, 1, 32'h4002, 0, 0);
        chk("R2 reg rev", mem_rev, 1);
        chk("R1 size half", mem_size, 1);
        op(0, 1, 0, 0, 1, 32'h4001, 0, 0);
        chk("R3 half misaligned", align_fault, 1);
        op(0, 1, 0, 0, 0, 32'h4003, 0, 0);
        chk("R1 byte any addr", {align_fault, mem_req, mem_size}, 4'b0100);
        op(0, 1, 1, 0, 1, 32'h4003, 0, 0);
        chk("R3 excl half no fault", {align_fault, mem_addr[1:0]}, 3'b000);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=<200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_pair_success();
        t_second_store_fails();
        t_trap_between();
        t_persist();
        t_qualifiers();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule